// File: doc/BRIEF.md
# Qualified Edge-Pulse Level Transfer

This block carries one control level to an output that is rebuilt by a set/reset latch. Nothing is copied straight from the input to the output. A high level on the input that lasts long enough produces a one-clock "set" strobe. A low level that lasts long enough produces a one-clock "clear" strobe. The latch turns these strobes back into a level.

Input runs shorter than the qualifying width for their polarity are swallowed, and the output keeps its last defined value. The turn-on and turn-off widths are separate parameters counted in clock cycles. The turn-off width is the longer one by default. Both strobes are brought out for observation.

A low `enable` clears the latch and blocks both strobes. The async active-low reset does the same.

Top module: `epx_edge_xfer`

## Requirements
- R1: During and after reset, before the first qualified input run, `dout`, `set_stb` and `clr_stb` are all 0.
- R2: When `din` has been sampled high on ON_CYC consecutive clock edges (default 3) with `enable` high, `set_stb` is 1 for exactly the next cycle.
- R3: When `din` has been sampled low on OFF_CYC consecutive clock edges (default 4) with `enable` high, `clr_stb` is 1 for exactly the next cycle.
- R4: A high run of `din` shorter than ON_CYC samples produces no `set_stb` and leaves `dout` unchanged.
- R5: A low run of `din` shorter than OFF_CYC samples produces no `clr_stb` and leaves `dout` unchanged.
- R6: `dout` rises only on the edge that ends a cycle in which `set_stb` was 1. It falls only on the edge that ends a cycle in which `clr_stb` was 1, or in which `enable` was 0. Otherwise it holds.
- R7: While `enable` is 0, both strobes stay 0 and `dout` is 0 from the next edge on. Once `enable` returns, the present `din` level is counted from its first sample. A high `din` therefore qualifies after ON_CYC samples.
- R8: `set_stb` and `clr_stb` are never 1 in the same cycle. If both reached the latch, clear would win.
- R9: A level held for any length after it qualifies produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| enable | input | 1 | Transfer enable; low clears the output and blocks the strobes |
| din | input | 1 | Control level to carry across |
| dout | output | 1 | Rebuilt level from the set/reset latch |
| set_stb | output | 1 | One-cycle turn-on strobe (debug) |
| clr_stb | output | 1 | One-cycle turn-off strobe (debug) |

## Verification
The hardest case to reach is a run that falls exactly one sample short of qualifying, placed right after the output has settled in the opposite state. It is also hard to reach when the run straddles an `enable` drop. To get there, the stimulus settles the output at each level. It then sweeps the opposite run length from one sample up past the qualifying width, for both polarities. After that it drops `enable` in the middle of a held high level and releases it again.

The bench keeps a per-edge run-length model of the levels it drives. From that model it predicts the exact cycle of each strobe and each output change.

// File: rtl/epx_pkg.sv
package epx_pkg;
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned width_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/epx_run_counter.sv
module epx_run_counter #(
  parameter int unsigned SAT = 5,
  parameter int unsigned CW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          din,
  output logic          lvl_q,
  output logic [CW-1:0] run_q
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  logic          lvl_d;
  logic [CW-1:0] run_d;

  always_comb begin
    lvl_d = lvl_q;
    run_d = run_q;
    if (!enable) begin
      lvl_d = 1'b0;
      run_d = SAT_V;
    end else if (din != lvl_q) begin
      lvl_d = din;
      run_d = ONE_V;
    end else if (run_q != SAT_V) begin
      run_d = run_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= SAT_V;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/epx_strobe_gen.sv
module epx_strobe_gen #(
  parameter int unsigned ON_CYC  = 3,
  parameter int unsigned OFF_CYC = 4,
  parameter int unsigned CW      = 3
) (
  input  logic          enable,
  input  logic          lvl_q,
  input  logic [CW-1:0] run_q,
  output logic          set_stb,
  output logic          clr_stb
);
  localparam logic [CW-1:0] ON_V  = CW'(ON_CYC);
  localparam logic [CW-1:0] OFF_V = CW'(OFF_CYC);

  always_comb begin
    set_stb = enable &&  lvl_q && (run_q == ON_V);
    clr_stb = enable && !lvl_q && (run_q == OFF_V);
  end
endmodule

// File: rtl/epx_sr_latch.sv
module epx_sr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_in,
  input  logic clr_in,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (!enable)     q_d = 1'b0;
    else if (clr_in) q_d = 1'b0;
    else if (set_in) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/epx_edge_xfer.sv
module epx_edge_xfer #(
  parameter int unsigned ON_CYC  = 3,
  parameter int unsigned OFF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic din,
  output logic dout,
  output logic set_stb,
  output logic clr_stb
);
  localparam int unsigned SAT = epx_pkg::max_u(ON_CYC, OFF_CYC) + 1;
  localparam int unsigned CW  = epx_pkg::width_for(SAT);

  logic          lvl_q;
  logic [CW-1:0] run_q;

  epx_run_counter #(.SAT(SAT), .CW(CW)) u_run (
    .clk(clk), .rst_n(rst_n), .enable(enable), .din(din),
    .lvl_q(lvl_q), .run_q(run_q)
  );

  epx_strobe_gen #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC), .CW(CW)) u_stb (
    .enable(enable), .lvl_q(lvl_q), .run_q(run_q),
    .set_stb(set_stb), .clr_stb(clr_stb)
  );

  epx_sr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .set_in(set_stb), .clr_in(clr_stb), .q(dout)
  );
endmodule

// File: rtl/epx_edge_xfer_chk.sv
module epx_edge_xfer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic din,
  input logic dout,
  input logic set_stb,
  input logic clr_stb
);
  // R2: turn-on strobe lasts one cycle and follows a high sample
  a_r2_set_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> !set_stb);
  a_r2_set_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |-> $past(din));
  // R3: turn-off strobe lasts one cycle and follows a low sample
  a_r3_clr_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> !clr_stb);
  a_r3_clr_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |-> !$past(din));
  // R6: output changes only through a strobe or a disable
  a_r6_rise_by_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> $past(set_stb));
  a_r6_fall_by_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout) |-> ($past(clr_stb) || !$past(enable)));
  // R7: disabled transfer forces the output low
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dout);
  // R8: strobes are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb && clr_stb));
endmodule

bind epx_edge_xfer epx_edge_xfer_chk u_chk (.*);

// File: tb/epx_edge_xfer_test.sv
module epx_edge_xfer_test;
  localparam int ON  = 3;
  localparam int OFF = 4;
  localparam int SAT = ((ON > OFF) ? ON : OFF) + 1;

  logic clk = 1'b0;
  logic rst_n, enable, din;
  logic dout, set_stb, clr_stb;

  int n_chk = 0;
  int n_fail = 0;
  int m_run;
  logic m_lvl, m_dout;
  int set_cnt, clr_cnt;

  always #4 clk = ~clk;

  epx_edge_xfer #(.ON_CYC(ON), .OFF_CYC(OFF)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .din(din),
    .dout(dout), .set_stb(set_stb), .clr_stb(clr_stb)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lvl = 1'b0; m_run = SAT; m_dout = 1'b0;
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic v, input logic e, input string tag);
    logic ps, pc;
    din = v; enable = e;
    @(posedge clk);
    ps = e && m_lvl && (m_run == ON);
    pc = e && !m_lvl && (m_run == OFF);
    if (!e) m_dout = 1'b0;
    else if (pc) m_dout = 1'b0;
    else if (ps) m_dout = 1'b1;
    if (!e) begin m_lvl = 1'b0; m_run = SAT; end
    else if (v != m_lvl) begin m_lvl = v; m_run = 1; end
    else if (m_run < SAT) m_run++;
    @(negedge clk);
    check("R2 set_stb", set_stb, e && m_lvl && (m_run == ON));
    check("R3 clr_stb", clr_stb, e && !m_lvl && (m_run == OFF));
    check(tag, dout, m_dout);
    check("R8 exclusive", set_stb && clr_stb, 1'b0);
    if (set_stb) set_cnt++;
    if (clr_stb) clr_cnt++;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; din = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 dout reset", dout, 1'b0);
    check("R1 set_stb reset", set_stb, 1'b0);
    check("R1 clr_stb reset", clr_stb, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R1 dout idle");

    // R4 sweep: high runs from settled low
    for (int w = 1; w <= ON + 3; w++) begin
      set_cnt = 0;
      for (int i = 0; i < w; i++) step(1'b1, 1'b1, "R4 dout high run");
      for (int i = 0; i < OFF + 3; i++) step(1'b0, 1'b1, "R6 dout settle low");
      check("R4 set count", set_cnt == ((w >= ON) ? 1 : 0), 1'b1);
    end

    // R5 sweep: low runs from settled high
    for (int i = 0; i < ON + 3; i++) step(1'b1, 1'b1, "R6 dout settle high");
    for (int w = 1; w <= OFF + 3; w++) begin
      clr_cnt = 0;
      for (int i = 0; i < w; i++) step(1'b0, 1'b1, "R5 dout low run");
      check("R5 clr count", clr_cnt == ((w >= OFF) ? 1 : 0), 1'b1);
      for (int i = 0; i < ON + 3; i++) step(1'b1, 1'b1, "R6 dout settle high");
    end

    // R9: long hold yields a single strobe
    set_cnt = 0;
    for (int i = 0; i < OFF + 2; i++) step(1'b0, 1'b1, "R9 dout");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, "R9 dout hold");
    check("R9 one set strobe", set_cnt == 1, 1'b1);

    // R7: disable in a held high level, then re-enable
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R7 dout disabled");
    check("R7 dout low", dout, 1'b0);
    set_cnt = 0;
    for (int i = 0; i < ON + 2; i++) step(1'b1, 1'b1, "R7 dout reenabled");
    check("R7 requalify", set_cnt == 1, 1'b1);
    check("R7 dout back high", dout, 1'b1);

    // mixed pattern with disable blips and alternating runs
    for (int k = 0; k < 60; k++)
      step(((k / 3) % 2) == 1, (k % 17) != 5, "R6 dout mixed");
    for (int k = 0; k < 60; k++)
      step(((k / 5) % 2) == 0, 1'b1, "R6 dout mixed2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule